// File: doc/BRIEF.md
# Lockable Crash Dump Readout

This block keeps a snapshot of a wide diagnostic bus taken at the moment of a system reset, so that software can inspect the state of the chip after the restart. The bus carries a fixed number of 32-bit words. A capture happens only when software has armed it through an enable bit, and every system reset disarms that bit again, so at most one snapshot is taken for each arming. The block's own reset is separate from the system reset event. A snapshot therefore outlives any number of system resets and is replaced only by a later armed capture.

Software reaches the block through four 32-bit registers on a request/response port with valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or the pending response is being taken in the same cycle. Each accepted request produces exactly one response one cycle later. That response holds `rsp_valid` and `rsp_rdata` unchanged until `rsp_ready` is high. Before acceptance a request may be withdrawn. The snapshot is read one word at a time: software writes a word index into the control register and then reads the value register. A lock register, once cleared, freezes the control register until the block itself is reset.

Top module: `dump_readout`

## Requirements
- R1: After a block reset the registers read as follows: lock = 1, control = 0 (capture off, index 0), and every snapshot word = 0.
- R2: Lock register (offset 0x0, bit 0) behaviour:
  - Writing 0 to bit 0 clears it.
  - Writing 1 never sets it.
  - A system reset does not set it.
  - Only a block reset returns it to 1.
- R3: While the lock bit is 0, writes to the control register leave both its fields unchanged.
- R4: Control register (offset 0x4) layout:
  - Bit 0 is the capture enable.
  - Bits [7:4] are the word index.
  - Both fields read back as written while unlocked; all other bits read 0.
- R5: A system reset event (`sys_rst_i` high for a cycle) forces the capture enable to 0.
- R6: A system reset event while the capture enable is 1 latches every word of `dump_i` into the snapshot on the same edge that clears the enable. Word k is `dump_i[32k+31:32k]`.
- R7: The attribute register (offset 0x8) reads NWORDS in bits [3:0] and 0 elsewhere. Writes to it have no effect.
- R8: The value register (offset 0xC) reads the snapshot word selected by the index. An index at or above NWORDS reads 0. Writes to it have no effect.
- R9: The snapshot changes only through an armed capture. A system reset with capture disabled leaves it intact.
- R10: Port handshake rules:
  - While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold and `req_ready` is low.
  - A request offered in that state is not accepted.
- R11: When a control write and a system reset event land on the same edge, the index takes the written value and the enable ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset, asynchronous assert |
| sys_rst_i | input | 1 | One-cycle system reset event |
| dump_i | input | NWORDS*32 | Diagnostic bus, word k in bits [32k+31:32k] |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address; bits [3:2] select the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The properties assume that every input is synchronous to `clk` and that `sys_rst_i` is a clean level sampled at the edge. They place no hold requirement on a request before acceptance, because the port allows a request to be withdrawn. The bench follows these assumptions:
- It drives all inputs on the falling edge.
- It pulses `sys_rst_i` for exactly one cycle.
- It changes `dump_i` only away from a reset event, so the captured value is the one present at the event edge.
- It offers a request during a stalled response and then withdraws it, which exercises the case where acceptance is refused without breaking the handshake rules.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_LOCK  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_ATTR  = 2'd2,
    SEL_VALUE = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IDX_LSB = 4;
endpackage

// File: rtl/cdr_regport.sv
module cdr_regport
  import cdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [REG_W-1:0] rd_value,
  input  logic             rsp_ready,
  output logic             req_ready,
  output logic             req_fire,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cdr_ctrl.sv
module cdr_ctrl
  import cdr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst_i,
  input  logic             wr_lock,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  output logic             lock_q,
  output logic             cap_en,
  output logic [IDX_W-1:0] rd_idx
);
  logic ctrl_open;
  assign ctrl_open = wr_ctrl && lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (wr_lock) begin
      lock_q <= lock_q & wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en <= 1'b0;
    end else if (sys_rst_i) begin
      cap_en <= 1'b0;
    end else if (ctrl_open) begin
      cap_en <= wdata[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
    end else if (ctrl_open) begin
      rd_idx <= wdata[CTRL_IDX_LSB +: IDX_W];
    end
  end
endmodule

// File: rtl/cdr_snapshot.sv
module cdr_snapshot
  import cdr_pkg::*;
#(
  parameter int NWORDS = 6,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [NWORDS*REG_W-1:0] dump_i,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [REG_W-1:0]        rd_word,
  output logic [NWORDS*REG_W-1:0] snap_flat
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NWORDS);

  logic [REG_W-1:0] word_q [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (capture) begin
        word_q[w] <= dump_i[w*REG_W +: REG_W];
      end
    end
    assign snap_flat[w*REG_W +: REG_W] = word_q[w];
  end

  always_comb begin
    rd_word = '0;
    if ({1'b0, rd_idx} < LIMIT) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (rd_idx == IDX_W'(w)) rd_word = word_q[w];
      end
    end
  end
endmodule

// File: rtl/dump_readout.sv
module dump_readout
  import cdr_pkg::*;
#(
  parameter int NWORDS = 6,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sys_rst_i,
  input  logic [NWORDS*REG_W-1:0] dump_i,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [3:0]              req_addr,
  input  logic [REG_W-1:0]        req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [REG_W-1:0]        rsp_rdata
);
  reg_sel_e                sel;
  logic                    req_fire;
  logic                    lock_q;
  logic                    cap_en;
  logic [IDX_W-1:0]        rd_idx;
  logic [REG_W-1:0]        rd_word;
  logic [REG_W-1:0]        rd_value;
  logic [NWORDS*REG_W-1:0] snap_flat;
  logic                    wr_fire;

  assign sel     = reg_sel_e'(req_addr[3:2]);
  assign wr_fire = req_fire && req_write;

  cdr_regport u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_value  (rd_value),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .req_fire  (req_fire),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  cdr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_i (sys_rst_i),
    .wr_lock   (wr_fire && sel == SEL_LOCK),
    .wr_ctrl   (wr_fire && sel == SEL_CTRL),
    .wdata     (req_wdata),
    .lock_q    (lock_q),
    .cap_en    (cap_en),
    .rd_idx    (rd_idx)
  );

  cdr_snapshot #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (sys_rst_i && cap_en),
    .dump_i    (dump_i),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .snap_flat (snap_flat)
  );

  always_comb begin
    rd_value = '0;
    unique case (sel)
      SEL_LOCK:  rd_value[0] = lock_q;
      SEL_CTRL: begin
        rd_value[CTRL_EN_BIT] = cap_en;
        rd_value[CTRL_IDX_LSB +: IDX_W] = rd_idx;
      end
      SEL_ATTR:  rd_value[IDX_W-1:0] = IDX_W'(NWORDS);
      SEL_VALUE: rd_value = rd_word;
      default:   rd_value = '0;
    endcase
  end
endmodule

// File: rtl/dump_readout_chk.sv
module dump_readout_chk #(
  parameter int NWORDS = 6,
  parameter int IDX_W  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sys_rst_i,
  input logic [NWORDS*32-1:0] dump_i,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [3:0]           req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_rdata,
  input logic                 lock_q,
  input logic                 cap_en,
  input logic [IDX_W-1:0]     rd_idx,
  input logic [NWORDS*32-1:0] snap_flat
);
  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  // R3
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr[3:2] == 2'd1 && !lock_q)
      |=> $stable(rd_idx));

  // R5
  sysrst_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> !cap_en);

  // R6
  capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && cap_en) |=> snap_flat == $past(dump_i));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_i && cap_en) |=> $stable(snap_flat));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind dump_readout dump_readout_chk #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst_i (sys_rst_i),
  .dump_i    (dump_i),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .lock_q    (lock_q),
  .cap_en    (cap_en),
  .rd_idx    (rd_idx),
  .snap_flat (snap_flat)
);

// File: tb/dump_readout_test.sv
module dump_readout_test;
  localparam int NW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sys_rst_i = 1'b0;
  logic [NW*32-1:0] dump_i = '0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_write = 1'b0;
  logic [3:0]     req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [31:0]    rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dump_readout #(.NWORDS(NW), .IDX_W(4)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k, input int seed);
    return 32'hA5000000 ^ (32'(seed) << 12) ^ (32'(k) * 32'h01010101);
  endfunction

  task automatic load_dump(input int seed);
    for (int k = 0; k < NW; k++) dump_i[k*32 +: 32] = pat(k, seed);
  endtask

  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     input bit with_sysrst, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    sys_rst_i = with_sysrst;
    @(negedge clk);
    req_valid = 1'b0; sys_rst_i = 1'b0;
    r = rsp_valid ? rsp_rdata : 32'hDEADBEEF;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, 1'b0, r);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r);
    bus(1'b0, a, 32'h0, 1'b0, r);
  endtask

  task automatic pulse_sysrst();
    @(negedge clk); sys_rst_i = 1'b1;
    @(negedge clk); sys_rst_i = 1'b0;
  endtask

  task automatic block_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] r;
    rd(4'h0, r); check("R1 lock", r, 32'h1);
    rd(4'h4, r); check("R1 ctrl", r, 32'h0);
    rd(4'hC, r); check("R1 word0", r, 32'h0);
  endtask

  task automatic t_ctrl_attr();
    logic [31:0] r;
    wr(4'h4, 32'hFFFF_FF5E);
    rd(4'h4, r); check("R4 ctrl readback", r, 32'h50);
    wr(4'h4, 32'h0000_0031);
    rd(4'h4, r); check("R4 ctrl en+idx", r, 32'h31);
    rd(4'h8, r); check("R7 attr", r, 32'(NW));
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, r); check("R7 attr write ignored", r, 32'(NW));
  endtask

  task automatic t_capture();
    logic [31:0] r;
    wr(4'h4, 32'h1);
    load_dump(1);
    pulse_sysrst();
    load_dump(2);
    rd(4'h4, r); check("R5 enable cleared", r, 32'h0);
    for (int k = 0; k < NW; k++) begin
      wr(4'h4, 32'(k) << 4);
      rd(4'hC, r); check("R6 captured word", r, pat(k, 1));
    end
    wr(4'h4, 32'(NW) << 4);
    rd(4'hC, r); check("R8 index at count", r, 32'h0);
    wr(4'h4, 32'hF0);
    rd(4'hC, r); check("R8 index 15", r, 32'h0);
    wr(4'hC, 32'h1234_5678);
    wr(4'h4, 32'h20);
    rd(4'hC, r); check("R8 value write ignored", r, pat(2, 1));
  endtask

  task automatic t_disarmed_sysrst();
    logic [31:0] r;
    load_dump(3);
    pulse_sysrst();
    wr(4'h4, 32'h40);
    rd(4'hC, r); check("R9 snapshot kept", r, pat(4, 1));
    wr(4'h4, 32'h1);
    load_dump(4);
    pulse_sysrst();
    wr(4'h4, 32'h50);
    rd(4'hC, r); check("R6 recapture", r, pat(5, 4));
  endtask

  task automatic t_collision();
    logic [31:0] r;
    bus(1'b1, 4'h4, 32'h31, 1'b1, r);
    rd(4'h4, r); check("R11 collide", r, 32'h30);
  endtask

  task automatic t_backpressure();
    logic [31:0] r;
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h8;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h0; req_wdata = 32'h0;
    check("R10 stalled valid", 32'(rsp_valid), 32'h1);
    check("R10 ready low", 32'(req_ready), 32'h0);
    repeat (2) @(negedge clk);
    check("R10 data held", rsp_rdata, 32'(NW));
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 32'h0);
    rd(4'h0, r); check("R10 withdrawn write", r, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] r;
    wr(4'h4, 32'h21);
    wr(4'h0, 32'h1);
    rd(4'h0, r); check("R2 write 1 keeps", r, 32'h1);
    wr(4'h0, 32'h0);
    rd(4'h0, r); check("R2 cleared", r, 32'h0);
    wr(4'h0, 32'h1);
    rd(4'h0, r); check("R2 no re-arm", r, 32'h0);
    wr(4'h4, 32'h50);
    rd(4'h4, r); check("R3 ctrl frozen", r, 32'h21);
    pulse_sysrst();
    rd(4'h0, r); check("R2 sysrst no re-arm", r, 32'h0);
    rd(4'h4, r); check("R5 locked disarm", r, 32'h20);
    block_reset();
    rd(4'h0, r); check("R1 lock after reset", r, 32'h1);
    rd(4'h4, r); check("R1 ctrl after reset", r, 32'h0);
    rd(4'hC, r); check("R1 snapshot cleared", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ctrl_attr();
    t_capture();
    t_disarmed_sysrst();
    t_collision();
    t_backpressure();
    t_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule